// File: doc/BRIEF.md
# Segmented capacitor DAC decoder

This block turns a 14-bit frequency-tuning word into the switch controls of a segmented capacitor bank. The upper 10 bits form a unit-cell count. That count is mapped onto a 32 by 32 grid of equal cells through row and column thermometer codes. Every row below the active row is fully on. In the active row, only the cells whose column index is below the column code are on. The lower 4 bits pass straight through to four binary-weighted switches that sit outside the grid.

A new word is taken only on a clock edge where the update strobe is high. Every output is a register, so a change of code reaches the whole bank in one cycle and never partly. The number of enabled unit cells always equals the upper-field value. As a result, the total capacitance steps by exactly one unit per code step, with no missing or reversed steps.

Top module: `cdac_seg_dec`

## Requirements
- R1: While rst_ni is low, all of row_therm_o, row_cur_o, col_therm_o, cell_en_o and lsb_o are zero.
- R2: If upd_i is low at a clock edge, no output changes at that edge, whatever word_i does.
- R3: After an update edge, lsb_o equals word_i[3:0] as sampled at that edge. Bit k drives the switch of weight 2^k.
- R4: After an update edge with M = word_i[13:4], row_therm_o[i] is 1 exactly when i < M / 32.
- R5: After an update edge, col_therm_o[j] is 1 exactly when j < M % 32.
- R6: After an update edge, row_cur_o is one-hot at bit M / 32.
- R7: Cell r*32+c of cell_en_o is on exactly when row r is fully on, or when r is the active row and col_therm_o[c] is 1. Equivalently, cell index k is on exactly when k < M.
- R8: The number of ones in cell_en_o equals M for every M from 0 to 1023. An increasing code therefore never removes a cell.
- R9: All outputs from one update appear together in the first cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 14 | Tuning word: upper 10 bits give the cell count, lower 4 bits the binary switches |
| upd_i | input | 1 | Update strobe; the word is loaded on an edge where this is high |
| row_therm_o | output | 32 | Row lines, thermometer code of fully-on rows |
| row_cur_o | output | 32 | One-hot select of the partially filled row |
| col_therm_o | output | 32 | Column lines, thermometer code within the active row |
| cell_en_o | output | 1024 | Per-cell enables, index row*32+column |
| lsb_o | output | 4 | Binary-weighted switch lines |

## Verification
The assertions check four properties on every cycle. The enabled-cell count matches the loaded upper field. The switch outputs hold whenever the strobe is low. The active-row select is at most one-hot. The row and column codes stay in thermometer form. Only the bench scenarios can show that each field lands on the right bit positions for specific codes. These include the row boundaries at multiples of 32, the extremes 0 and 1023, and a full upward sweep plus a downward run. The bench also shows that a reset after a non-zero code clears the whole bank.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  localparam int unsigned DEF_LSB_W = 4;
  localparam int unsigned DEF_ROW_W = 5;
  localparam int unsigned DEF_COL_W = 5;
  localparam int unsigned DEF_WORD_W = DEF_LSB_W + DEF_ROW_W + DEF_COL_W;
endpackage

// File: rtl/cdac_therm_dec.sv
module cdac_therm_dec #(
  parameter int unsigned IN_W  = 5,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_N-1:0] therm_o,
  output logic [OUT_N-1:0] onehot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_bit
    localparam logic [IN_W-1:0] IDX = IN_W'(i);
    assign therm_o[i]  = (val_i > IDX);
    assign onehot_o[i] = (val_i == IDX);
  end
endmodule

// File: rtl/cdac_cell_array.sv
module cdac_cell_array #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32
) (
  input  logic [ROWS-1:0]      row_therm_i,
  input  logic [ROWS-1:0]      row_cur_i,
  input  logic [COLS-1:0]      col_therm_i,
  output logic [ROWS*COLS-1:0] cell_en_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      // full row, or partial fill of the active row
      assign cell_en_o[r*COLS+c] = row_therm_i[r] | (row_cur_i[r] & col_therm_i[c]);
    end
  end
endmodule

// File: rtl/cdac_seg_dec.sv
module cdac_seg_dec
  import cdac_pkg::*;
#(
  parameter int unsigned LSB_W  = DEF_LSB_W,
  parameter int unsigned ROW_W  = DEF_ROW_W,
  parameter int unsigned COL_W  = DEF_COL_W,
  localparam int unsigned MSB_W  = ROW_W + COL_W,
  localparam int unsigned WORD_W = LSB_W + MSB_W,
  localparam int unsigned ROWS   = 1 << ROW_W,
  localparam int unsigned COLS   = 1 << COL_W,
  localparam int unsigned CELLS  = ROWS * COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              upd_i,
  output logic [ROWS-1:0]   row_therm_o,
  output logic [ROWS-1:0]   row_cur_o,
  output logic [COLS-1:0]   col_therm_o,
  output logic [CELLS-1:0]  cell_en_o,
  output logic [LSB_W-1:0]  lsb_o
);
  logic [MSB_W-1:0] msb_d;
  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;
  logic [ROWS-1:0]  row_therm_d, row_cur_d;
  logic [COLS-1:0]  col_therm_d, col_unused;
  logic [CELLS-1:0] cell_en_d;
  logic [MSB_W-1:0] msb_q;

  assign msb_d   = word_i[WORD_W-1:LSB_W];
  assign row_idx = msb_d[MSB_W-1:COL_W];
  assign col_idx = msb_d[COL_W-1:0];

  cdac_therm_dec #(.IN_W(ROW_W)) u_row_dec (
    .val_i(row_idx), .therm_o(row_therm_d), .onehot_o(row_cur_d)
  );

  cdac_therm_dec #(.IN_W(COL_W)) u_col_dec (
    .val_i(col_idx), .therm_o(col_therm_d), .onehot_o(col_unused)
  );

  cdac_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .row_therm_i(row_therm_d), .row_cur_i(row_cur_d),
    .col_therm_i(col_therm_d), .cell_en_o(cell_en_d)
  );

  // single load point: all switch groups move on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_therm_o <= '0;
      row_cur_o   <= '0;
      col_therm_o <= '0;
      cell_en_o   <= '0;
      lsb_o       <= '0;
      msb_q       <= '0;
    end else if (upd_i) begin
      row_therm_o <= row_therm_d;
      row_cur_o   <= row_cur_d;
      col_therm_o <= col_therm_d;
      cell_en_o   <= cell_en_d;
      lsb_o       <= word_i[LSB_W-1:0];
      msb_q       <= msb_d;
    end
  end

  assert_cell_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cell_en_o) == int'(msb_q));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(cell_en_o) && $stable(lsb_o) && $stable(row_cur_o)
               && $stable(row_therm_o) && $stable(col_therm_o)));

  assert_lsb_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> lsb_o == $past(word_i[LSB_W-1:0]));

  assert_row_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_cur_o));

  assert_row_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((row_therm_o + ROWS'(1)) & row_therm_o) == '0);

  assert_col_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((col_therm_o + COLS'(1)) & col_therm_o) == '0);

  assert_row_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_therm_o & row_cur_o) == '0);
endmodule

// File: tb/tb_cdac_seg_dec.sv
`timescale 1ns/1ps
module tb_cdac_seg_dec;
  localparam int ROWS = 32, COLS = 32, CELLS = 1024;

  typedef struct {
    logic [ROWS-1:0]  rt;
    logic [ROWS-1:0]  rc;
    logic [COLS-1:0]  ct;
    logic [CELLS-1:0] cells;
    logic [3:0]       lsb;
  } exp_t;

  logic clk = 0, rst_ni = 0, upd_i = 0;
  logic [13:0] word_i = '0;
  logic [ROWS-1:0] row_therm_o, row_cur_o;
  logic [COLS-1:0] col_therm_o;
  logic [CELLS-1:0] cell_en_o;
  logic [3:0] lsb_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];
  exp_t last;

  always #4 clk = ~clk;

  cdac_seg_dec dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word_i), .upd_i(upd_i),
    .row_therm_o(row_therm_o), .row_cur_o(row_cur_o), .col_therm_o(col_therm_o),
    .cell_en_o(cell_en_o), .lsb_o(lsb_o)
  );

  function automatic exp_t model(logic [13:0] w);
    exp_t e;
    int m, r, c;
    m = int'(w[13:4]);
    r = m / 32;
    c = m % 32;
    e.rt = '0; e.rc = '0; e.ct = '0; e.cells = '0;
    for (int i = 0; i < ROWS; i++) e.rt[i] = (i < r);
    for (int j = 0; j < COLS; j++) e.ct[j] = (j < c);
    e.rc[r] = 1'b1;
    for (int k = 0; k < CELLS; k++) e.cells[k] = (k < m);
    e.lsb = w[3:0];
    return e;
  endfunction

  task automatic chk(string req, logic [CELLS-1:0] act, logic [CELLS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compare(exp_t e, string tag);
    chk({tag, " R4 row_therm"}, CELLS'(row_therm_o), CELLS'(e.rt));
    chk({tag, " R6 row_cur"},   CELLS'(row_cur_o),   CELLS'(e.rc));
    chk({tag, " R5 col_therm"}, CELLS'(col_therm_o), CELLS'(e.ct));
    chk({tag, " R7 cells"},     cell_en_o,           e.cells);
    chk({tag, " R3 lsb"},       CELLS'(lsb_o),       CELLS'(e.lsb));
    chk({tag, " R8 count"},     CELLS'($countones(cell_en_o)), CELLS'($countones(e.cells)));
  endtask

  // driver: one strobe, expected item pushed to scoreboard
  task automatic apply(logic [13:0] w);
    @(negedge clk);
    word_i = w;
    upd_i  = 1'b1;
    last   = model(w);
    q.push_back(last);
    @(negedge clk);
    upd_i  = 1'b0;
  endtask

  // monitor: R9 all fields checked in the first cycle after the strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_ni && upd_i) begin
        @(negedge clk);
        if (q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R9 act=update exp=no_pending_item");
        end else compare(q.pop_front(), "R9");
      end
    end
  end

  task automatic chk_zero(string tag);
    chk({tag, " R1 row_therm"}, CELLS'(row_therm_o), '0);
    chk({tag, " R1 row_cur"},   CELLS'(row_cur_o),   '0);
    chk({tag, " R1 col_therm"}, CELLS'(col_therm_o), '0);
    chk({tag, " R1 cells"},     cell_en_o,           '0);
    chk({tag, " R1 lsb"},       CELLS'(lsb_o),       '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_zero("reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_zero("post_reset");

    apply(14'h0000);
    apply(14'h000F);
    apply(14'h3FFF);
    apply(14'h0010);
    apply(14'h0200);
    apply(14'h01F0);
    apply(14'h0205);
    apply(14'h2000);
    apply(14'h3FF0);

    // R8 full upward sweep of the unit field
    for (int m = 0; m < 1024; m++) apply({m[9:0], m[3:0]});
    // downward run across a row boundary
    for (int m = 70; m >= 20; m--) apply({m[9:0], 4'(m)});

    // R2 strobe low: word changes, outputs hold
    apply(14'h1A5C);
    @(negedge clk);
    word_i = 14'h0BEE;
    repeat (4) begin
      @(negedge clk);
      word_i = ~word_i;
      compare(last, "R2 hold");
    end

    // R1 reset after a non-zero code
    apply(14'h2ABC);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk_zero("mid_reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_zero("after_mid_reset");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 act=%0d pending exp=0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule